// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Controller

This block keeps the bookkeeping for eight circular buffers that live in one external single-port memory. The buffers form two groups of four. Group A holds buffers 0 to 3 and group B holds buffers 4 to 7. Software gives each buffer a first address, a last address, a capacity and a block length. Software also turns each buffer on and off through a separate enable vector. Producers and consumers, such as an I/O sequencer or a processor, raise a request line per buffer, with a direction bit that selects push or pop.

Each cycle, one fixed-priority arbiter picks a single request. The controller then turns that request into a memory command: an address plus a write or read strobe. It moves the buffer's write or read pointer and its fill level. When a programmed number of pushes has landed in a buffer, it pulses that buffer's event line. The same pulse can start coprocessor work or serve as a host interrupt.

The requesting agent drives and takes the memory data itself. The controller supplies only the address and the strobes.

Top module: `shmem_ring_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, `gnt`, `mem_en`, `err` and `evt` are all zero, and every fill level reads zero.
- R2: Setting a buffer's enable bit while the bit was clear loads both of its pointers with its first address and clears its fill level and block counter. This takes effect at the write's clock edge.
- R3: A granted push to a buffer that is not full does three things one cycle later. It sets `mem_en=1` and `mem_we=1`, and it puts the buffer's write pointer on `mem_addr`. It also raises the fill level by one.
- R4: A granted pop from a buffer that is not empty does the same with `mem_we=0` and the read pointer, and it lowers the fill level by one.
- R5: A pointer that sits on the buffer's last address moves next to the buffer's first address. Any other pointer moves up by one.
- R6: `gnt` is combinational, one-hot or zero. Among the enabled requesters, the lowest index wins, so A0 beats A3 and A3 beats every B buffer.
- R7: A request to a buffer whose enable bit is clear gets no grant, no memory command and no error, and it leaves the fill level unchanged.
- R8: A granted push to a full buffer (fill level equal to capacity) pulses `err` for that buffer for one cycle, one cycle later. It issues no memory command and leaves the pointers and fill level unchanged.
- R9: A granted pop from an empty buffer behaves the same way as R8.
- R10: A block counter counts each successful push. When the count reaches a nonzero block length, the buffer's `evt` bit goes high for one cycle, in step with that push's memory command, and the counter restarts from zero. A block length of zero never raises an event.
- R11: Configuration writes take `cfg_sel` as the buffer index. `cfg_field` selects the register: 0 is the first address, 1 the last address, 2 the capacity and 3 the block length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 3 | Buffer index for a configuration write |
| cfg_field | input | 2 | Register selector for a configuration write |
| cfg_wdata | input | 24 | Configuration write data |
| en_we | input | 1 | Enable vector write strobe |
| en_wdata | input | 8 | New enable vector, one bit per buffer |
| req | input | 8 | Request line, one per buffer |
| req_pop | input | 8 | Direction per buffer: 1 for pop, 0 for push |
| gnt | output | 8 | One-hot grant for the current cycle |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 24 | Memory address |
| err | output | 8 | Overflow or underflow pulse, one bit per buffer |
| evt | output | 8 | Block-complete pulse, one bit per buffer |
| fill | output | 192 | Fill levels, buffer i in bits [24i+23:24i] |

## Verification
The grant is combinational, so the bench samples it one time step after it drives a request, before the next rising edge. The memory command, the error and event pulses and the new fill level all appear one edge after the grant, so the bench samples them on the following falling edge. The driver computes the expected address and direction from its own pointer model and queues them. A monitor checks every `mem_en` cycle against the head of that queue, so a missing, extra or late command shows up as a mismatch.

// File: rtl/shmem_ring_pkg.sv
package shmem_ring_pkg;
  localparam int unsigned ADDR_W = 24;

  typedef enum logic [1:0] {
    FLD_FIRST = 2'd0,
    FLD_LAST  = 2'd1,
    FLD_CAP   = 2'd2,
    FLD_BLK   = 2'd3
  } cfg_field_e;

  typedef struct packed {
    logic [ADDR_W-1:0] first_a;
    logic [ADDR_W-1:0] last_a;
    logic [ADDR_W-1:0] cap;
    logic [ADDR_W-1:0] blk_len;
  } ring_cfg_t;
endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
  import shmem_ring_pkg::*;
#(
  parameter int unsigned NBUF = 8,
  localparam int unsigned SW = $clog2(NBUF)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SW-1:0]          cfg_sel,
  input  logic [1:0]             cfg_field,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  input  logic                   en_we,
  input  logic [NBUF-1:0]        en_wdata,
  output ring_cfg_t [NBUF-1:0]   cfg_o,
  output logic [NBUF-1:0]        en_o,
  output logic [NBUF-1:0]        load_o
);
  ring_cfg_t [NBUF-1:0] cfg_q, cfg_n;
  logic [NBUF-1:0]      en_q, en_n;

  always_comb begin
    cfg_n = cfg_q;
    if (cfg_we) begin
      unique case (cfg_field_e'(cfg_field))
        FLD_FIRST: cfg_n[cfg_sel].first_a = cfg_wdata;
        FLD_LAST:  cfg_n[cfg_sel].last_a  = cfg_wdata;
        FLD_CAP:   cfg_n[cfg_sel].cap     = cfg_wdata;
        default:   cfg_n[cfg_sel].blk_len = cfg_wdata;
      endcase
    end
  end

  always_comb begin
    en_n   = en_we ? en_wdata : en_q;
    load_o = en_we ? (en_wdata & ~en_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_n;
    end
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;

  // R2
  load_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o != '0) |=> ((en_q & $past(load_o)) == $past(load_o)));
endmodule

// File: rtl/ring_arb.sv
module ring_arb #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end

  // R6
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R6
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0) && ((req != '0) == (gnt != '0)));
endmodule

// File: rtl/ring_slot.sv
module ring_slot
  import shmem_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  ring_cfg_t         cfg,
  input  logic              push_go,
  input  logic              pop_go,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] rptr,
  output logic [ADDR_W-1:0] count,
  output logic              full,
  output logic              empty,
  output logic              evt,
  output logic              err
);
  logic [ADDR_W-1:0] wptr_n, rptr_n, cnt_n, blk_q, blk_n;
  logic              push_ok, pop_ok, upd, evt_n, err_n;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] p,
                                             input ring_cfg_t c);
    return (p == c.last_a) ? c.first_a : p + 1'b1;
  endfunction

  assign full    = (count == cfg.cap);
  assign empty   = (count == '0);
  assign push_ok = push_go && !full;
  assign pop_ok  = pop_go && !empty;
  assign upd     = load || push_ok || pop_ok;

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    cnt_n  = count;
    blk_n  = blk_q;
    evt_n  = 1'b0;
    err_n  = (push_go && full) || (pop_go && empty);
    if (load) begin
      wptr_n = cfg.first_a;
      rptr_n = cfg.first_a;
      cnt_n  = '0;
      blk_n  = '0;
      err_n  = 1'b0;
    end else if (push_ok) begin
      wptr_n = step(wptr, cfg);
      cnt_n  = count + 1'b1;
      if (cfg.blk_len != '0 && (blk_q + 1'b1) == cfg.blk_len) begin
        blk_n = '0;
        evt_n = 1'b1;
      end else begin
        blk_n = blk_q + 1'b1;
      end
    end else if (pop_ok) begin
      rptr_n = step(rptr, cfg);
      cnt_n  = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      blk_q <= '0;
    end else if (upd) begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= cnt_n;
      blk_q <= blk_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt <= 1'b0;
      err <= 1'b0;
    end else begin
      evt <= evt_n;
      err <= err_n;
    end
  end

  // R8
  full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_go && full && !load) |=> (count == $past(count) && wptr == $past(wptr)));
  // R9
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_go && empty && !load) |=> (count == $past(count) && rptr == $past(rptr)));
  // R10
  evt_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(push_ok));
  // R5
  wrap_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !load && wptr == cfg.last_a) |=> (wptr == $past(cfg.first_a)));
endmodule

// File: rtl/shmem_ring_ctrl.sv
module shmem_ring_ctrl
  import shmem_ring_pkg::*;
#(
  parameter int unsigned NBUF = 8,
  localparam int unsigned SW = $clog2(NBUF)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SW-1:0]            cfg_sel,
  input  logic [1:0]               cfg_field,
  input  logic [ADDR_W-1:0]        cfg_wdata,
  input  logic                     en_we,
  input  logic [NBUF-1:0]          en_wdata,
  input  logic [NBUF-1:0]          req,
  input  logic [NBUF-1:0]          req_pop,
  output logic [NBUF-1:0]          gnt,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [NBUF-1:0]          err,
  output logic [NBUF-1:0]          evt,
  output logic [NBUF*ADDR_W-1:0]   fill
);
  ring_cfg_t [NBUF-1:0] cfg_v;
  logic [NBUF-1:0]      en_v, load_v, full_v, empty_v, req_eff;
  logic [ADDR_W-1:0]    wptr_v [NBUF];
  logic [ADDR_W-1:0]    rptr_v [NBUF];
  logic [SW-1:0]        win;
  logic                 any;
  logic                 ok_n, we_n;
  logic [ADDR_W-1:0]    addr_n;

  ring_cfg_regs #(.NBUF(NBUF)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .en_we(en_we), .en_wdata(en_wdata),
    .cfg_o(cfg_v), .en_o(en_v), .load_o(load_v)
  );

  assign req_eff = req & en_v;

  ring_arb #(.N(NBUF)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_eff), .gnt(gnt), .idx(win), .any(any)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    ring_slot u_slot (
      .clk(clk), .rst_n(rst_n), .load(load_v[g]), .cfg(cfg_v[g]),
      .push_go(gnt[g] & ~req_pop[g]), .pop_go(gnt[g] & req_pop[g]),
      .wptr(wptr_v[g]), .rptr(rptr_v[g]), .count(fill[g*ADDR_W +: ADDR_W]),
      .full(full_v[g]), .empty(empty_v[g]), .evt(evt[g]), .err(err[g])
    );
  end

  always_comb begin
    we_n   = !req_pop[win];
    ok_n   = any && !load_v[win] && (we_n ? !full_v[win] : !empty_v[win]);
    addr_n = we_n ? wptr_v[win] : rptr_v[win];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en <= 1'b0;
    end else begin
      mem_en <= ok_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else if (ok_n) begin
      mem_we   <= we_n;
      mem_addr <= addr_n;
    end
  end

  // R3
  access_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> $past(any));
  // R8
  no_access_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err != '0) |-> (!mem_en && $onehot(err)));
  // R7
  disabled_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~en_v) == '0));
endmodule

// File: tb/shmem_ring_ctrl_test.sv
module shmem_ring_ctrl_test;
  localparam int N = 8;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, en_we, mem_en, mem_we;
  logic [2:0] cfg_sel;
  logic [1:0] cfg_field;
  logic [AW-1:0] cfg_wdata, mem_addr;
  logic [N-1:0] en_wdata, req, req_pop, gnt, err, evt;
  logic [N*AW-1:0] fill;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  int m_first[N], m_last[N], m_cap[N], m_blk[N];
  int m_w[N], m_r[N], m_c[N], m_b[N];
  logic [AW:0] exp_q[$];

  always #5 clk = ~clk;

  shmem_ring_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .en_we(en_we), .en_wdata(en_wdata), .req(req), .req_pop(req_pop),
    .gnt(gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .err(err), .evt(evt),
    .fill(fill)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int b, input int p);
    return (p == m_last[b]) ? m_first[b] : p + 1;
  endfunction

  // monitor: compares each memory command against the head of the queue
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_en === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R3/R4 unexpected access", {7'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
      end else begin
        logic [AW:0] e;
        e = exp_q.pop_front();
        chk("R3/R4 access", {7'd0, mem_we, mem_addr}, {7'd0, e});
      end
    end
  end

  task automatic cfg_wr(input int b, input int f, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(b); cfg_field = 2'(f); cfg_wdata = AW'(v);
    case (f)
      0: m_first[b] = v;
      1: m_last[b]  = v;
      2: m_cap[b]   = v;
      default: m_blk[b] = v;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic en_wr(input logic [N-1:0] v, input logic [N-1:0] prev);
    @(negedge clk);
    en_we = 1'b1; en_wdata = v;
    for (int b = 0; b < N; b++) begin
      if (v[b] && !prev[b]) begin
        m_w[b] = m_first[b]; m_r[b] = m_first[b]; m_c[b] = 0; m_b[b] = 0;
      end
    end
    @(negedge clk);
    en_we = 1'b0;
  endtask

  // applies model for a granted op; returns ok and event expectation
  task automatic model_op(input int b, input bit pop, output bit ok, output bit ev);
    ev = 1'b0;
    if (pop) begin
      ok = (m_c[b] != 0);
      if (ok) begin
        exp_q.push_back({1'b0, AW'(m_r[b])});
        m_r[b] = nxt(b, m_r[b]); m_c[b]--;
      end
    end else begin
      ok = (m_c[b] != m_cap[b]);
      if (ok) begin
        exp_q.push_back({1'b1, AW'(m_w[b])});
        m_w[b] = nxt(b, m_w[b]); m_c[b]++;
        if (m_blk[b] != 0 && m_b[b] + 1 == m_blk[b]) begin
          m_b[b] = 0; ev = 1'b1;
        end else begin
          m_b[b]++;
        end
      end
    end
  endtask

  task automatic op(input int b, input bit pop, input string tag);
    bit ok, ev;
    @(negedge clk);
    req[b] = 1'b1; req_pop[b] = pop;
    #1;
    chk({"R6 grant ", tag}, 32'(gnt), 32'(1 << b));
    model_op(b, pop, ok, ev);
    @(negedge clk);
    req[b] = 1'b0; req_pop[b] = 1'b0;
    #1;
    chk({"R8/R9 err ", tag}, 32'(err[b]), 32'(!ok));
    chk({"R10 evt ", tag}, 32'(evt[b]), 32'(ev));
    chk({"R3/R4 fill ", tag}, 32'(fill[b*AW +: AW]), 32'(m_c[b]));
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ok, ev;
    rst_n = 1'b0; cfg_we = 1'b0; en_we = 1'b0; cfg_sel = '0; cfg_field = '0;
    cfg_wdata = '0; en_wdata = '0; req = '0; req_pop = '0;
    for (int b = 0; b < N; b++) begin
      m_first[b] = 0; m_last[b] = 0; m_cap[b] = 0; m_blk[b] = 0;
      m_w[b] = 0; m_r[b] = 0; m_c[b] = 0; m_b[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    chk("R1 gnt", 32'(gnt), 0);
    chk("R1 mem_en", 32'(mem_en), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 evt", 32'(evt), 0);
    chk("R1 fill", 32'(fill != '0), 0);

    // R11 field encoding: 0 first, 1 last, 2 capacity, 3 block length
    cfg_wr(0, 0, 'h100); cfg_wr(0, 1, 'h103); cfg_wr(0, 2, 4);  cfg_wr(0, 3, 3);
    cfg_wr(5, 0, 'h200); cfg_wr(5, 1, 'h209); cfg_wr(5, 2, 10); cfg_wr(5, 3, 0);
    cfg_wr(2, 0, 'h300); cfg_wr(2, 1, 'h30F); cfg_wr(2, 2, 16); cfg_wr(2, 3, 1);
    en_wr(8'b0010_0001, 8'h00);
    #1;
    chk("R2 fill after enable", 32'(fill[0 +: AW]), 0);

    // R3 pushes, R10 event on third, R11 first address used
    op(0, 1'b0, "R3 push0");
    op(0, 1'b0, "R3 push1");
    op(0, 1'b0, "R10 push2 block");
    op(0, 1'b0, "R3 push3 full");
    op(0, 1'b0, "R8 push on full");
    // R4 pops, R9 underflow
    for (int k = 0; k < 4; k++) op(0, 1'b1, "R4 pop");
    op(0, 1'b1, "R9 pop on empty");
    // R5 wrap: write pointer back at first address
    op(0, 1'b0, "R5 wrap push");
    op(0, 1'b1, "R5 wrap pop");

    // R10 block length zero never fires; R8 overflow on B1
    for (int k = 0; k < 12; k++) op(5, 1'b0, "R10 zero block len");

    // R6 priority: A0 push against B1 pop
    @(negedge clk);
    req[0] = 1'b1; req[5] = 1'b1; req_pop[5] = 1'b1;
    #1;
    chk("R6 A0 over B1", 32'(gnt), 32'h01);
    model_op(0, 1'b0, ok, ev);
    @(negedge clk);
    req[0] = 1'b0;
    #1;
    chk("R6 B1 after A0", 32'(gnt), 32'h20);
    model_op(5, 1'b1, ok, ev);
    @(negedge clk);
    req[5] = 1'b0; req_pop[5] = 1'b0;
    #1;
    chk("R6 fill B1", 32'(fill[5*AW +: AW]), 32'(m_c[5]));

    // R7 disabled buffer ignored
    @(negedge clk);
    req[2] = 1'b1;
    #1;
    chk("R7 no grant", 32'(gnt), 0);
    @(negedge clk);
    req[2] = 1'b0;
    #1;
    chk("R7 no access", 32'(mem_en), 0);
    chk("R7 no err", 32'(err), 0);
    chk("R7 fill", 32'(fill[2*AW +: AW]), 0);

    // R2 re-enable resets pointers and fill
    en_wr(8'b0010_0000, 8'b0010_0001);
    en_wr(8'b0010_0001, 8'b0010_0000);
    #1;
    chk("R2 fill cleared", 32'(fill[0 +: AW]), 0);
    op(0, 1'b0, "R2 push after reload");

    repeat (3) @(negedge clk);
    chk("R3/R4 queue drained", 32'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule